// File: doc/BRIEF.md
# Flash Erase and Busy-Poll Sequencer

This block runs whole serial-flash maintenance operations in hardware, so software never has to poll the flash. It sits in front of a serial flash controller and drives that controller's transaction interface. It issues transaction requests, flush requests and stop requests. It consumes the bytes that come back and reports the result through a single-cycle completion pulse, a sticky error flag and an assembled device identifier.

A one-cycle `start` with a two-bit operation code launches one of four operations:

- **Sector erase.** Write-enable, then the erase with a three-byte address, then busy polling.
- **Whole-chip erase.** Write-enable, then the erase with no address, then busy polling.
- **Identifier read.** Flush, then a three-byte read.
- **Write-disable.** A single command.

Busy polling works in three steps:

- It flushes the controller FIFOs and opens one continuous status read.
- It inspects bit 0 of each returned byte and waits a fixed number of clock cycles between busy readings.
- It gives up with an error once a per-operation limit of busy readings has been exceeded.

Top module: `flash_maint_seq`

## Requirements
- R1: After reset `busy`, `done`, `error`, `tx_start`, `flush_req` and `stop_req` are low and `dev_id` is zero.
- R2: `op_sel` selects the operation, taken when `start` is accepted: 0 sector erase, 1 chip erase, 2 identifier read, 3 write-disable. Each erase first issues a write transaction with opcode 0x06, `tx_addr_bytes`=0 and `tx_write`=1, and waits for `tx_done`.
- R3: Sector erase then issues a write transaction with opcode `SECT_OP` (default 0x20) and `tx_addr_bytes`=3. Its `tx_addr` equals the `sector_addr` sampled with `start`.
- R4: Chip erase then issues a write transaction with opcode `CHIP_OP` (default 0xC7) and `tx_addr_bytes`=0.
- R5: After an erase, the block pulses `flush_req` and waits for `flush_done`. It then issues a read with opcode 0x05, `tx_addr_bytes`=0 and `tx_rd_count`=0 (continuous). The first status byte with bit 0 clear causes `stop_req`, and the `tx_done` that follows ends the operation.
- R6: An identifier read first flushes, then issues a read with opcode 0x9F and `tx_rd_count`=3, then issues `stop_req` after the third byte. The first, second and third bytes land in `dev_id[7:0]`, `[15:8]` and `[23:16]`.
- R7: `dev_id` changes only during an identifier read.
- R8: `done` is high for exactly one cycle at the end of every operation. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` rises, where `busy` is low.
- R9: Write-disable issues a single write transaction with opcode 0x04 and no address. It ends on `tx_done` with no flush and no stop.
- R10: A `start` received while `busy` is high is ignored.
- R11: If the status byte still has bit 0 set after `SECT_LIMIT` (sector erase, default 1000) or `CHIP_LIMIT` (chip erase, default 10000) busy bytes, the block sets `error`, issues `stop_req` and completes. Such a run consumes exactly limit+1 status bytes.
- R12: `error` holds until the next accepted `start` and is low in the cycle after that start.
- R13: When status data is always available, consecutive status bytes after a busy byte are accepted exactly `POLL_CYC`+2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| op_sel | input | 2 | Operation code (see R2) |
| sector_addr | input | ADDR_W | Sector erase address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Busy-poll timeout flag |
| dev_id | output | 24 | Assembled identifier |
| tx_start | output | 1 | One-cycle transaction request |
| tx_opcode | output | 8 | Instruction byte |
| tx_addr | output | ADDR_W | Address for the transaction |
| tx_addr_bytes | output | 2 | Address byte count (0 or 3) |
| tx_write | output | 1 | 1 write direction, 0 read |
| tx_rd_count | output | 2 | Bytes to read, 0 continuous |
| tx_done | input | 1 | Write transaction or stop completed |
| flush_req | output | 1 | One-cycle FIFO flush request |
| flush_done | input | 1 | Flush completed |
| stop_req | output | 1 | One-cycle request to end a read |
| rx_valid | input | 1 | Read byte available |
| rx_data | input | 8 | Read byte |
| rx_ready | output | 1 | Read byte accepted when valid |

## Verification
A corrupted state register shows up at once on the transaction outputs. The result is a wrong opcode or address count in the next request, a missing flush before a read, or a stop that never comes. Each of these is visible within a few cycles of the controller's handshake. A wrong busy-poll counter is slower to show: it only reveals itself when the number of status bytes consumed before the error differs from limit+1, or when the gap between status reads differs from the pause length. A bad identifier byte index places the returned bytes in the wrong lanes of `dev_id`, which is visible as soon as the third byte is taken.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_WEN, S_ERS, S_FLS, S_STAT, S_PAUSE, S_IDRD, S_STOP, S_WDIS
    } fseq_state_e;

    typedef enum logic [1:0] {
        OP_SECT = 2'd0,
        OP_CHIP = 2'd1,
        OP_ID   = 2'd2,
        OP_WDIS = 2'd3
    } fseq_op_e;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_RDID = 8'h9F;
endpackage

// File: rtl/fseq_poll_timer.sv
module fseq_poll_timer #(
    parameter int LIM_W    = 14,
    parameter int PAUSE_W  = 3,
    parameter int POLL_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             hit,
    input  logic [LIM_W-1:0] limit,
    output logic             over,
    output logic             waiting
);
    typedef struct packed {
        logic [LIM_W-1:0]   tries;
        logic [PAUSE_W-1:0] wcnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (arm) begin
            tmr_d.tries = '0;
            tmr_d.wcnt  = '0;
        end else if (hit) begin
            tmr_d.tries = tmr_q.tries + 1'b1;
            tmr_d.wcnt  = PAUSE_W'(POLL_CYC);
        end else if (tmr_q.wcnt != '0) begin
            tmr_d.wcnt = tmr_q.wcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign over    = (tmr_q.tries == limit);
    assign waiting = (tmr_q.wcnt != '0);

    // R11: the sequencer never counts a busy reading past the limit
    p_no_hit_over_r11: assert property (@(posedge clk) disable iff (!rst_n)
        over |-> !hit);
endmodule

// File: rtl/fseq_id_pack.sv
module fseq_id_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [1:0]  idx,
    input  logic [7:0]  din,
    output logic [23:0] id
);
    logic [23:0] id_d, id_q;

    always_comb begin
        id_d = id_q;
        for (int b = 0; b < 3; b++) begin
            if (load && idx == 2'(b)) id_d[8*b +: 8] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_q <= '0;
        else        id_q <= id_d;
    end

    assign id = id_q;

    p_lane1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && idx == 2'd1) |=> (id[15:8] == $past(din)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(id));
endmodule

// File: rtl/flash_maint_seq.sv
module flash_maint_seq
    import fseq_pkg::*;
#(
    parameter int         ADDR_W     = 24,
    parameter logic [7:0] SECT_OP    = 8'h20,
    parameter logic [7:0] CHIP_OP    = 8'hC7,
    parameter int         SECT_LIMIT = 1000,
    parameter int         CHIP_LIMIT = 10000,
    parameter int         POLL_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic [ADDR_W-1:0] sector_addr,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [23:0]       dev_id,
    output logic              tx_start,
    output logic [7:0]        tx_opcode,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [1:0]        tx_addr_bytes,
    output logic              tx_write,
    output logic [1:0]        tx_rd_count,
    input  logic              tx_done,
    output logic              flush_req,
    input  logic              flush_done,
    output logic              stop_req,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready
);
    localparam int BIG_LIM = (CHIP_LIMIT > SECT_LIMIT) ? CHIP_LIMIT : SECT_LIMIT;
    localparam int LIM_W   = $clog2(BIG_LIM + 1);
    localparam int PAUSE_W = $clog2(POLL_CYC + 2);

    typedef struct packed {
        fseq_state_e       st;
        fseq_op_e          op;
        logic              txs;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] adr;
        logic [1:0]        nadr;
        logic              wr;
        logic [1:0]        cnt;
        logic              fl;
        logic              sp;
        logic              dn;
        logic              er;
        logic [1:0]        idx;
    } seq_t;

    seq_t q_q, q_d;
    logic arm, hit, id_ld, over, wait_busy, rdy;
    logic [LIM_W-1:0] limit;

    assign limit = (q_q.op == OP_CHIP) ? LIM_W'(CHIP_LIMIT) : LIM_W'(SECT_LIMIT);

    fseq_poll_timer #(.LIM_W(LIM_W), .PAUSE_W(PAUSE_W), .POLL_CYC(POLL_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .limit(limit),
        .over(over), .waiting(wait_busy)
    );

    fseq_id_pack idp_i (
        .clk(clk), .rst_n(rst_n), .load(id_ld), .idx(q_q.idx), .din(rx_data), .id(dev_id)
    );

    always_comb begin
        q_d     = q_q;
        q_d.txs = 1'b0;
        q_d.fl  = 1'b0;
        q_d.sp  = 1'b0;
        q_d.dn  = 1'b0;
        arm     = 1'b0;
        hit     = 1'b0;
        id_ld   = 1'b0;
        rdy     = 1'b0;
        case (q_q.st)
            S_IDLE: if (start) begin
                q_d.er   = 1'b0;
                q_d.op   = fseq_op_e'(op_sel);
                q_d.adr  = sector_addr;
                q_d.nadr = 2'd0;
                q_d.cnt  = 2'd0;
                q_d.wr   = 1'b1;
                if (fseq_op_e'(op_sel) == OP_ID) begin
                    q_d.fl = 1'b1;
                    q_d.st = S_FLS;
                end else begin
                    q_d.txs = 1'b1;
                    q_d.opc = (fseq_op_e'(op_sel) == OP_WDIS) ? OPC_WRDI : OPC_WREN;
                    q_d.st  = (fseq_op_e'(op_sel) == OP_WDIS) ? S_WDIS : S_WEN;
                end
            end
            S_WEN: if (tx_done) begin
                q_d.txs  = 1'b1;
                q_d.opc  = (q_q.op == OP_SECT) ? SECT_OP : CHIP_OP;
                q_d.nadr = (q_q.op == OP_SECT) ? 2'd3 : 2'd0;
                q_d.st   = S_ERS;
            end
            S_ERS: if (tx_done) begin
                q_d.fl = 1'b1;
                q_d.st = S_FLS;
            end
            S_FLS: if (flush_done) begin
                q_d.txs  = 1'b1;
                q_d.wr   = 1'b0;
                q_d.nadr = 2'd0;
                if (q_q.op == OP_ID) begin
                    q_d.opc = OPC_RDID;
                    q_d.cnt = 2'd3;
                    q_d.idx = 2'd0;
                    q_d.st  = S_IDRD;
                end else begin
                    q_d.opc = OPC_RDSR;
                    q_d.cnt = 2'd0;
                    arm     = 1'b1;
                    q_d.st  = S_STAT;
                end
            end
            S_STAT: begin
                rdy = 1'b1;
                if (rx_valid) begin
                    if (!rx_data[0]) begin
                        q_d.sp = 1'b1;
                        q_d.st = S_STOP;
                    end else if (over) begin
                        q_d.er = 1'b1;
                        q_d.sp = 1'b1;
                        q_d.st = S_STOP;
                    end else begin
                        hit    = 1'b1;
                        q_d.st = S_PAUSE;
                    end
                end
            end
            S_PAUSE: if (!wait_busy) q_d.st = S_STAT;
            S_IDRD: begin
                rdy = 1'b1;
                if (rx_valid) begin
                    id_ld   = 1'b1;
                    q_d.idx = q_q.idx + 1'b1;
                    if (q_q.idx == 2'd2) begin
                        q_d.sp = 1'b1;
                        q_d.st = S_STOP;
                    end
                end
            end
            S_STOP, S_WDIS: if (tx_done) begin
                q_d.dn = 1'b1;
                q_d.st = S_IDLE;
            end
            default: q_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign busy          = (q_q.st != S_IDLE);
    assign done          = q_q.dn;
    assign error         = q_q.er;
    assign tx_start      = q_q.txs;
    assign tx_opcode     = q_q.opc;
    assign tx_addr       = q_q.adr;
    assign tx_addr_bytes = q_q.nadr;
    assign tx_write      = q_q.wr;
    assign tx_rd_count   = q_q.cnt;
    assign flush_req     = q_q.fl;
    assign stop_req      = q_q.sp;
    assign rx_ready      = rdy;

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_wren_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !op_sel[1]) |=> (tx_start && tx_opcode == 8'h06 && tx_write));
    p_clear_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == S_STAT && rx_valid && !rx_data[0]) |=> stop_req);
    p_timeout_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == S_STAT && rx_valid && rx_data[0] && over) |=> (error && stop_req));
    p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> !error);
    p_pause_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == S_PAUSE && wait_busy) |=> (q_q.st == S_PAUSE && !rx_ready));
endmodule

// File: tb/flash_maint_seq_tb_top.sv
`timescale 1ns/1ps
module flash_maint_seq_tb_top;
    localparam logic [7:0] SOP = 8'h20;
    localparam logic [7:0] COP = 8'hC7;
    localparam int SLIM = 1000;
    localparam int CLIM = 10000;
    localparam int PC   = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic [23:0] sector_addr = 24'h0;
    logic busy, done, error, tx_start, tx_write, flush_req, stop_req, rx_ready;
    logic [23:0] dev_id, tx_addr;
    logic [7:0] tx_opcode;
    logic [1:0] tx_addr_bytes, tx_rd_count;
    logic tx_done = 1'b0, flush_done = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;

    always #10 clk = ~clk;

    flash_maint_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .sector_addr(sector_addr),
        .busy(busy), .done(done), .error(error), .dev_id(dev_id),
        .tx_start(tx_start), .tx_opcode(tx_opcode), .tx_addr(tx_addr),
        .tx_addr_bytes(tx_addr_bytes), .tx_write(tx_write), .tx_rd_count(tx_rd_count),
        .tx_done(tx_done), .flush_req(flush_req), .flush_done(flush_done),
        .stop_req(stop_req), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    int checks = 0, fails = 0;
    logic [40:0] log_q[$];
    logic [40:0] exp_q[$];
    logic [7:0] id_bytes[3] = '{8'hC2, 8'h20, 8'h17};
    int cfg_busy = 0, busy_left = 0, mode = 0, id_pos = 0;
    int txd_cnt = 0, fl_cnt = 0, takes = 0, gap_err = 0, cyc = 0, last_take = 0;
    bit pend_take = 0, prev_busy_byte = 0, mdl_busy = 0, st_edge = 0, done_prev = 0;

    function automatic logic [40:0] mk_tx(logic [7:0] o, logic [1:0] n, logic w,
                                          logic [1:0] c, logic [23:0] a);
        return {4'd0, o, n, w, c, a};
    endfunction
    localparam logic [40:0] FL = {4'd1, 37'd0};
    localparam logic [40:0] SP = {4'd2, 37'd0};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) st_edge <= start;

    // controller emulation and per-clock model
    always @(negedge clk) begin
        cyc++;
        if (pend_take) begin
            takes++;
            if (mode == 1) begin
                if (prev_busy_byte && (cyc - last_take) != PC + 2) gap_err++;
                prev_busy_byte = rx_data[0];
                last_take = cyc;
                if (busy_left > 0) busy_left--;
            end else if (mode == 2) begin
                id_pos++;
                if (id_pos == 3) mode = 0;
            end
        end
        tx_done = 1'b0;
        flush_done = 1'b0;
        if (txd_cnt > 0) begin txd_cnt--; if (txd_cnt == 0) tx_done = 1'b1; end
        if (fl_cnt > 0) begin fl_cnt--; if (fl_cnt == 0) flush_done = 1'b1; end
        if (rst_n && tx_start) begin
            log_q.push_back(mk_tx(tx_opcode, tx_addr_bytes, tx_write, tx_rd_count,
                                  (tx_addr_bytes != 2'd0) ? tx_addr : 24'h0));
            if (tx_write) txd_cnt = 3;
            else begin
                mode = (tx_rd_count == 2'd0) ? 1 : 2;
                id_pos = 0;
                busy_left = cfg_busy;
                prev_busy_byte = 0;
            end
        end
        if (rst_n && flush_req) begin log_q.push_back(FL); fl_cnt = 2; end
        if (rst_n && stop_req) begin log_q.push_back(SP); mode = 0; txd_cnt = 2; end
        rx_valid = (mode != 0);
        rx_data = (mode == 1) ? ((busy_left != 0) ? 8'h03 : 8'h02) :
                  (mode == 2) ? id_bytes[id_pos] : 8'h00;
        pend_take = rx_valid && rx_ready;
        if (rst_n) begin
            if (done) mdl_busy = 0;
            else if (st_edge && !mdl_busy) mdl_busy = 1;
            chk(busy == mdl_busy, "R8 busy", busy, mdl_busy);         // R8 / R10
            chk(!(done && done_prev), "R8 done width", done, 0);
            done_prev = done;
        end
    end

    task automatic cmp_log(input string req);
        chk(log_q.size() == exp_q.size(), req, log_q.size(), exp_q.size());
        if (log_q.size() == exp_q.size())
            foreach (exp_q[i]) chk(log_q[i] == exp_q[i], req, log_q[i], exp_q[i]);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input int nb,
                          input bit poke, output int ntake, output int ngap);
        int t0, g0, n;
        cfg_busy = nb;
        log_q.delete();
        t0 = takes; g0 = gap_err;
        @(negedge clk); start = 1'b1; op_sel = op; sector_addr = a;
        @(negedge clk); start = 1'b0; sector_addr = 24'hFFFFFF;
        chk(error == 1'b0 && busy == 1'b1, "R12 error cleared on start", error, 0);
        n = 0;
        while (!done && n < 150000) begin
            @(negedge clk); n++;
            if (poke && n == 6) begin start = 1'b1; op_sel = 2'd2; end
            if (poke && n == 7) start = 1'b0;
        end
        chk(done == 1'b1, "R8 op completes", done, 1);
        @(negedge clk);
        ntake = takes - t0;
        ngap = gap_err - g0;
    endtask

    initial begin
        #(20ns * 190000);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nt, ng;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !error && !tx_start && !flush_req && !stop_req && dev_id == 24'h0,
            "R1 reset state", {busy, done, error, tx_start, flush_req, stop_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 identifier read
        run_op(2'd2, 24'h0, 0, 0, nt, ng);
        exp_q = '{FL, mk_tx(8'h9F, 2'd0, 1'b0, 2'd3, 24'h0), SP};
        cmp_log("R6 id sequence");
        chk(dev_id == 24'h1720C2, "R6 id byte order", dev_id, 24'h1720C2);
        chk(nt == 3, "R6 id bytes taken", nt, 3);

        // R2 R3 R5 R13 sector erase with three busy readings
        run_op(2'd0, 24'h123456, 3, 0, nt, ng);
        exp_q = '{mk_tx(8'h06, 2'd0, 1'b1, 2'd0, 24'h0), mk_tx(SOP, 2'd3, 1'b1, 2'd0, 24'h123456),
                  FL, mk_tx(8'h05, 2'd0, 1'b0, 2'd0, 24'h0), SP};
        cmp_log("R3 sector sequence");
        chk(nt == 4, "R5 status bytes taken", nt, 4);
        chk(ng == 0, "R13 poll spacing", ng, 0);
        chk(error == 1'b0, "R5 no error", error, 0);
        chk(dev_id == 24'h1720C2, "R7 id kept after erase", dev_id, 24'h1720C2);

        // R4 chip erase ready at once
        run_op(2'd1, 24'h0, 0, 0, nt, ng);
        exp_q = '{mk_tx(8'h06, 2'd0, 1'b1, 2'd0, 24'h0), mk_tx(COP, 2'd0, 1'b1, 2'd0, 24'h0),
                  FL, mk_tx(8'h05, 2'd0, 1'b0, 2'd0, 24'h0), SP};
        cmp_log("R4 chip sequence");
        chk(nt == 1, "R4 status bytes taken", nt, 1);

        // R9 write-disable
        run_op(2'd3, 24'h0, 0, 0, nt, ng);
        exp_q = '{mk_tx(8'h04, 2'd0, 1'b1, 2'd0, 24'h0)};
        cmp_log("R9 write-disable sequence");

        // R10 start while busy is ignored
        run_op(2'd0, 24'hABCDE0, 5, 1, nt, ng);
        exp_q = '{mk_tx(8'h06, 2'd0, 1'b1, 2'd0, 24'h0), mk_tx(SOP, 2'd3, 1'b1, 2'd0, 24'hABCDE0),
                  FL, mk_tx(8'h05, 2'd0, 1'b0, 2'd0, 24'h0), SP};
        cmp_log("R10 start ignored");
        chk(nt == 6, "R10 status bytes taken", nt, 6);
        @(negedge clk);
        chk(busy == 1'b0, "R10 no extra op", busy, 0);

        // R11 sector timeout
        run_op(2'd0, 24'h000100, -1, 0, nt, ng);
        chk(error == 1'b1, "R11 sector timeout error", error, 1);
        chk(nt == SLIM + 1, "R11 sector reads before error", nt, SLIM + 1);
        chk(log_q.size() == 5 && log_q[4] == SP, "R11 stop after timeout", log_q.size(), 5);
        chk(ng == 0, "R13 poll spacing long run", ng, 0);
        repeat (3) @(negedge clk);
        chk(error == 1'b1, "R12 error held", error, 1);

        // R11 chip timeout, then R12 clear
        run_op(2'd1, 24'h0, -1, 0, nt, ng);
        chk(error == 1'b1, "R11 chip timeout error", error, 1);
        chk(nt == CLIM + 1, "R11 chip reads before error", nt, CLIM + 1);
        run_op(2'd3, 24'h0, 0, 0, nt, ng);
        chk(error == 1'b0, "R12 error cleared after next op", error, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule